// File: doc/BRIEF.md
# Command-Queue SPI Master

This block is an SPI master that works through a list of transfers without host help once it has been started. The host fills three small per-entry stores that share one index: a command store holding the chip-select pattern and a width-select flag for each transfer, a transmit store with the outgoing words, and a receive store where each incoming word lands. It then sets the clock mode, the clock divider, the wide-transfer width and a pair of queue pointers, and writes a start bit. The block runs every entry from the start pointer to the end pointer inclusive, wrapping past the last slot, and raises a done flag.

While the queue is not running, the serial clock and the four chip-selects are driven from an idle-level register. Software sets this register to the levels that the attached slaves expect when the bus is quiet, so that handing the pins back produces no stray edge. An active-low slave-select input is watched while the queue runs. If another device pulls it low, a mode fault is recorded, the queue stops at once and the pins return to their idle levels. An open-drain option turns every output into a pull-down-only driver through its output enable.

The host port is a flat word space. Address bits [5:4] select the region: 0 registers, 1 command store, 2 transmit store, 3 receive store (read only); bits [3:0] give the entry index. Registers: 0 control ([0] clock polarity, [1] clock phase, [2] open-drain, [7:3] wide width), 1 divider N, 2 pointers ([3:0] start, [7:4] end), 3 idle levels ([0] clock, [4:1] chip-selects, reset value clock 0 and chip-selects 4'hF), 4 run/status (write [0] start, write [2] clear mode fault; read [0] running, [1] done, [2] mode fault).

Top module: `cmdq_spi_master`

## Requirements
- R1: The clock rests at the polarity bit. With phase 0, MISO is sampled on the leading clock edge and MOSI changes on the trailing edge, the first bit being present before the first edge; with phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R2: Words are shifted most significant bit first in both directions.
- R3: A transfer is 8 bits when command bit [4] is clear; when it is set, the width is control bits [7:3] clamped to the range 8 to 16.
- R4: The serial clock period is 2×N system clocks, N being the divider register, with values below 2 treated as 2.
- R5: Entries from the start pointer to the end pointer inclusive run in order, the index wrapping from 15 to 0; each transfer drives the chip-selects with command bits [3:0], sends the transmit entry of its index and writes the received word, zero-extended, into the receive entry of its index.
- R6: When the entry at the end pointer completes, the done flag is set and the running flag clears; a new start clears done.
- R7: While not running, the clock output equals idle bit [0] and the chip-selects equal idle bits [4:1].
- R8: A low level on the slave-select input while running (seen after a two-flop synchronizer) stops the queue, sets the mode-fault flag, clears the running flag and returns the pins to idle levels; a later start after clearing the fault runs normally.
- R9: A start request is ignored while the queue is running or while the mode-fault flag is set; writing run bit [2] clears the mode-fault flag.
- R10: With open-drain set, each output enable is low whenever its output is high; with it clear, all output enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host word address (region and index) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| cs_o | output | 4 | Chip-select outputs |
| cs_oe | output | 4 | Chip-select output enables |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low slave-select input, mode-fault source |

## Verification
A behavioural slave follows the bus in all four clock modes and catches a design that samples on the wrong edge or shifts the first bit late, since every word would come out rotated or shifted by one bit. Mixed 8-bit, 12-bit and 16-bit entries, a width request of 20, and a queue that wraps from slot 15 to slot 0 expose a wrong clamp, a lost wrap or a receive word filed under the wrong index. Divider values 0 and 5 catch a wrong clock period, and a second start written mid-run would show up as surplus clock edges. A mode fault injected mid-word must leave the pins at idle levels and refuse a start until the flag is cleared; a design that kept clocking or restarted would fail these checks.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
    localparam int Q_DEPTH = 16;
    localparam int QAW     = $clog2(Q_DEPTH);
    localparam int W_MIN   = 8;
    localparam int W_MAX   = 16;
    localparam int WB      = $clog2(W_MAX + 1);
    localparam int CNT_W   = WB + 1;
    localparam int CS_N    = 4;
    localparam int DIV_W   = 8;
    localparam int ADDR_W  = QAW + 2;
    localparam int ST_W    = 3;

    typedef enum logic [1:0] {
        SP_REG = 2'd0,
        SP_CMD = 2'd1,
        SP_TX  = 2'd2,
        SP_RX  = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_DIV  = 3'd1,
        RG_PTR  = 3'd2,
        RG_IDLE = 3'd3,
        RG_RUN  = 3'd4
    } reg_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_XFER   = 2'd2
    } seq_e;

    typedef struct packed {
        logic [WB-1:0] wide_bits;
        logic          odrain;
        logic          cpha;
        logic          cpol;
    } ctrl_t;

    typedef struct packed {
        logic            wide;
        logic [CS_N-1:0] cs;
    } cmd_t;

    typedef struct packed {
        logic [CS_N-1:0] cs;
        logic            sck;
    } idle_t;

    function automatic logic [WB-1:0] clamp_width(input logic [WB-1:0] w);
        if (w < WB'(W_MIN)) return WB'(W_MIN);
        if (w > WB'(W_MAX)) return WB'(W_MAX);
        return w;
    endfunction

    function automatic logic [W_MAX-1:0] left_align(input logic [W_MAX-1:0] d,
                                                    input logic [WB-1:0] w);
        logic [WB-1:0] sh;
        sh = WB'(W_MAX) - w;
        return d << sh;
    endfunction
endpackage

// File: rtl/cqs_regfile.sv
module cqs_regfile
    import cqs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [W_MAX-1:0]  host_wdata,
    output logic [W_MAX-1:0]  host_rdata,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div,
    output logic [QAW-1:0]    start_ptr,
    output logic [QAW-1:0]    end_ptr,
    output idle_t             idle,
    output logic              start_req,
    output logic              modf_clr,
    input  logic [ST_W-1:0]   status,
    input  logic [QAW-1:0]    rd_idx,
    output cmd_t              cur_cmd,
    output logic [W_MAX-1:0]  cur_tx,
    input  logic              rx_we,
    input  logic [QAW-1:0]    rx_idx,
    input  logic [W_MAX-1:0]  rx_data
);
    cmd_t             cmd_mem [Q_DEPTH];
    logic [W_MAX-1:0] tx_mem  [Q_DEPTH];
    logic [W_MAX-1:0] rx_mem  [Q_DEPTH];

    space_e         space;
    logic [QAW-1:0] slot;
    reg_e           rsel;

    assign space = space_e'(host_addr[ADDR_W-1 -: 2]);
    assign slot  = host_addr[QAW-1:0];
    assign rsel  = reg_e'(slot[2:0]);

    always_ff @(posedge clk) begin
        start_req <= 1'b0;
        modf_clr  <= 1'b0;
        if (rst) begin
            ctrl      <= '0;
            div       <= DIV_W'(2);
            start_ptr <= '0;
            end_ptr   <= '0;
            idle      <= '{cs: '1, sck: 1'b0};
            for (int i = 0; i < Q_DEPTH; i++) begin
                cmd_mem[i] <= '0;
                tx_mem[i]  <= '0;
            end
        end else if (host_we) begin
            case (space)
                SP_REG: begin
                    case (rsel)
                        RG_CTRL: ctrl <= ctrl_t'(host_wdata[$bits(ctrl_t)-1:0]);
                        RG_DIV:  div  <= host_wdata[DIV_W-1:0];
                        RG_PTR: begin
                            start_ptr <= host_wdata[QAW-1:0];
                            end_ptr   <= host_wdata[2*QAW-1:QAW];
                        end
                        RG_IDLE: idle <= idle_t'(host_wdata[$bits(idle_t)-1:0]);
                        RG_RUN: begin
                            start_req <= host_wdata[0];
                            modf_clr  <= host_wdata[2];
                        end
                        default: ;
                    endcase
                end
                SP_CMD:  cmd_mem[slot] <= cmd_t'(host_wdata[$bits(cmd_t)-1:0]);
                SP_TX:   tx_mem[slot]  <= host_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < Q_DEPTH; i++) rx_mem[i] <= '0;
        end else if (rx_we) begin
            rx_mem[rx_idx] <= rx_data;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (space)
            SP_REG: begin
                case (rsel)
                    RG_CTRL: host_rdata = W_MAX'(ctrl);
                    RG_DIV:  host_rdata = W_MAX'(div);
                    RG_PTR:  host_rdata = W_MAX'({end_ptr, start_ptr});
                    RG_IDLE: host_rdata = W_MAX'(idle);
                    RG_RUN:  host_rdata = W_MAX'(status);
                    default: host_rdata = '0;
                endcase
            end
            SP_CMD:  host_rdata = W_MAX'(cmd_mem[slot]);
            SP_TX:   host_rdata = tx_mem[slot];
            default: host_rdata = rx_mem[slot];
        endcase
    end

    assign cur_cmd = cmd_mem[rd_idx];
    assign cur_tx  = tx_mem[rd_idx];
endmodule

// File: rtl/cqs_baud.sv
module cqs_baud
    import cqs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] cnt;

    assign lim  = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    assign tick = run && (cnt == lim - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + DIV_W'(1);
    end

    // R4: the half-period counter never passes its limit while running
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt < lim);
endmodule

// File: rtl/cqs_shift.sv
module cqs_shift
    import cqs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             abort,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [WB-1:0]    width,
    input  logic [W_MAX-1:0] txd,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             sck,
    output logic             mosi,
    output logic [W_MAX-1:0] rxd,
    output logic             done
);
    logic [W_MAX-1:0] txsr;
    logic [W_MAX-1:0] rxsr;
    logic [CNT_W-1:0] ec;
    logic [WB-1:0]    wlat;
    logic [CNT_W-1:0] last_ec;
    logic [W_MAX-1:0] aligned;

    assign last_ec = {wlat, 1'b0};
    assign aligned = left_align(txd, width);
    assign rxd     = rxsr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sck  <= 1'b0;
            mosi <= 1'b0;
            txsr <= '0;
            rxsr <= '0;
            ec   <= '0;
            wlat <= WB'(W_MIN);
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
                sck  <= cpol;
            end else if (go) begin
                busy <= 1'b1;
                sck  <= cpol;
                ec   <= '0;
                wlat <= width;
                rxsr <= '0;
                mosi <= aligned[W_MAX-1];
                txsr <= cpha ? aligned : (aligned << 1);
            end else if (busy && tick) begin
                if (ec == last_ec) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    sck <= ~sck;
                    ec  <= ec + CNT_W'(1);
                    if (ec[0] == 1'b0) begin
                        if (cpha) begin
                            mosi <= txsr[W_MAX-1];
                            txsr <= txsr << 1;
                        end else begin
                            rxsr <= {rxsr[W_MAX-2:0], miso};
                        end
                    end else begin
                        if (cpha) begin
                            rxsr <= {rxsr[W_MAX-2:0], miso};
                        end else begin
                            mosi <= txsr[W_MAX-1];
                            txsr <= txsr << 1;
                        end
                    end
                end
            end else if (!busy) begin
                sck <= cpol;
            end
        end
    end

    // R3: edge count stays within twice the latched width
    a_r3_edge_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> ec <= last_ec);

    // R1: every word ends with the clock back at its resting level
    a_r1_sck_rest: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> sck == cpol);

    // R2: a finished word leaves the edge counter at its full value
    a_r2_full_word: assert property (@(posedge clk) disable iff (rst)
        done |-> ec == last_ec);
endmodule

// File: rtl/cmdq_spi_master.sv
module cmdq_spi_master
    import cqs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [W_MAX-1:0]  host_wdata,
    output logic [W_MAX-1:0]  host_rdata,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    output logic [CS_N-1:0]   cs_o,
    output logic [CS_N-1:0]   cs_oe,
    input  logic              miso_i,
    input  logic              ss_n_i
);
    ctrl_t            ctrl;
    idle_t            idle;
    cmd_t             cur_cmd;
    logic [DIV_W-1:0] div;
    logic [QAW-1:0]   start_ptr, end_ptr, idx;
    logic [W_MAX-1:0] cur_tx, sh_rxd;
    logic             start_req, modf_clr;
    logic             sh_busy, sh_sck, sh_mosi, sh_done, tick;
    logic             go, fault, active, rx_we;
    logic             done_f, modf_f, ss_meta, ss_sync;
    logic [WB-1:0]    xfer_w;
    seq_e             state;

    assign active = (state != SQ_IDLE);
    assign fault  = active && !ss_sync;
    assign go     = (state == SQ_LAUNCH) && !fault;
    assign rx_we  = (state == SQ_XFER) && sh_done && !fault;
    assign xfer_w = cur_cmd.wide ? clamp_width(ctrl.wide_bits) : WB'(W_MIN);

    cqs_regfile u_regs (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ctrl(ctrl), .div(div), .start_ptr(start_ptr), .end_ptr(end_ptr),
        .idle(idle), .start_req(start_req), .modf_clr(modf_clr),
        .status({modf_f, done_f, active}),
        .rd_idx(idx), .cur_cmd(cur_cmd), .cur_tx(cur_tx),
        .rx_we(rx_we), .rx_idx(idx), .rx_data(sh_rxd)
    );

    cqs_baud u_baud (
        .clk(clk), .rst(rst), .run(sh_busy), .div(div), .tick(tick)
    );

    cqs_shift u_shift (
        .clk(clk), .rst(rst), .go(go), .abort(fault),
        .cpol(ctrl.cpol), .cpha(ctrl.cpha), .width(xfer_w), .txd(cur_tx),
        .tick(tick), .miso(miso_i), .busy(sh_busy), .sck(sh_sck),
        .mosi(sh_mosi), .rxd(sh_rxd), .done(sh_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            done_f  <= 1'b0;
            modf_f  <= 1'b0;
            ss_meta <= 1'b1;
            ss_sync <= 1'b1;
        end else begin
            ss_meta <= ss_n_i;
            ss_sync <= ss_meta;
            if (modf_clr) modf_f <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start_req && !modf_f) begin
                        state  <= SQ_LAUNCH;
                        idx    <= start_ptr;
                        done_f <= 1'b0;
                    end
                end
                SQ_LAUNCH: state <= SQ_XFER;
                SQ_XFER: begin
                    if (sh_done) begin
                        if (idx == end_ptr) begin
                            state  <= SQ_IDLE;
                            done_f <= 1'b1;
                        end else begin
                            idx   <= idx + QAW'(1);
                            state <= SQ_LAUNCH;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
            if (fault) begin
                state  <= SQ_IDLE;
                modf_f <= 1'b1;
            end
        end
    end

    assign sck_o   = active ? sh_sck : idle.sck;
    assign cs_o    = active ? cur_cmd.cs : idle.cs;
    assign mosi_o  = sh_mosi;
    assign sck_oe  = ctrl.odrain ? ~sck_o  : 1'b1;
    assign mosi_oe = ctrl.odrain ? ~mosi_o : 1'b1;
    assign cs_oe   = ctrl.odrain ? ~cs_o   : '1;

    // R8: a synchronized slave-select fault stops the queue and flags it
    a_r8_fault_stop: assert property (@(posedge clk) disable iff (rst)
        fault |=> (state == SQ_IDLE) && modf_f);

    // R6: done only rises together with the queue going idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(done_f) |-> !active && !sh_busy);

    // R7: on completion the chip-selects already sit at their idle levels
    a_r7_idle_cs: assert property (@(posedge clk) disable iff (rst)
        $rose(done_f) |-> cs_o == idle.cs);

    // R9: a start while the fault flag is set does not launch
    a_r9_start_blocked: assert property (@(posedge clk) disable iff (rst)
        (start_req && modf_f && !active) |=> state == SQ_IDLE);

    // R10: open-drain outputs never drive a high level
    a_r10_open_drain: assert property (@(posedge clk) disable iff (rst)
        ctrl.odrain |-> !(sck_oe && sck_o) && !(mosi_oe && mosi_o) && ((cs_oe & cs_o) == '0));

    // R5: the shifter only starts from the launch state
    a_r5_launch_only: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_busy) |-> $past(state) == SQ_LAUNCH);
endmodule

// File: tb/cmdq_spi_master_test.sv
module cmdq_spi_master_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        sck_o, sck_oe, mosi_o, mosi_oe;
    logic [3:0]  cs_o, cs_oe;
    logic        miso_r = 1'b0;
    logic        ss_n = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    int extra_edges = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] mo;
        logic [15:0] mi;
        int          w;
        logic [3:0]  cs;
    } frame_t;

    frame_t      sb[$];
    logic [15:0] exp_rx [16];
    bit          tb_cpol = 0;
    bit          tb_cpha = 0;
    int          k = 0;
    logic [15:0] got = '0;
    bit          cs_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_spi_master uut (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .cs_o(cs_o), .cs_oe(cs_oe), .miso_i(miso_r), .ss_n_i(ss_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural slave and scoreboard monitor
    initial begin
        forever begin
            @(sck_o);
            if (sb.size() != 0) begin
                bit lead, samp;
                lead = (sck_o != tb_cpol);
                samp = tb_cpha ? !lead : lead;
                if (samp) begin
                    got = {got[14:0], mosi_o};
                    if (cs_o !== sb[0].cs) cs_bad = 1;
                    k++;
                    if (k == sb[0].w) begin
                        check(got == sb[0].mo, "R1 R2", "mosi word", 32'(got), 32'(sb[0].mo));
                        check(!cs_bad, "R5", "chip-select during word", 32'(cs_o), 32'(sb[0].cs));
                        void'(sb.pop_front());
                        k = 0;
                        got = '0;
                        cs_bad = 0;
                        if (sb.size() != 0 && !tb_cpha) miso_r = sb[0].mi[sb[0].w-1];
                    end
                end else begin
                    if (tb_cpha || k > 0) miso_r = sb[0].mi[sb[0].w-1-k];
                end
            end else begin
                extra_edges++;
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = a;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic set_mode(input bit cpol, input bit cpha, input bit od,
                            input logic [4:0] wbits, input logic [3:0] idle_cs);
        tb_cpol = cpol;
        tb_cpha = cpha;
        wr(6'd3, 16'({idle_cs, cpol}));
        wr(6'd0, 16'({wbits, od, cpha, cpol}));
    endtask

    task automatic load_entry(input int idx, input logic [3:0] cs, input bit wide,
                              input logic [15:0] tx, input logic [15:0] mi, input int w);
        frame_t f;
        logic [15:0] mask;
        mask = 16'((32'd1 << w) - 1);
        wr(6'(16 + idx), 16'({wide, cs}));
        wr(6'(32 + idx), tx);
        f.mo = tx & mask;
        f.mi = mi & mask;
        f.w  = w;
        f.cs = cs;
        sb.push_back(f);
        exp_rx[idx] = mi & mask;
    endtask

    task automatic start_q(input int st, input int en);
        wr(6'd2, 16'({4'(en), 4'(st)}));
        k = 0;
        got = '0;
        cs_bad = 0;
        if (sb.size() != 0) miso_r = sb[0].mi[sb[0].w-1];
        wr(6'd4, 16'h0001);
    endtask

    task automatic wait_q(input int st, input int en, input logic [3:0] idle_cs);
        logic [15:0] d;
        int i;
        int t;
        t = 0;
        rd(6'd4, d);
        while (d[0] && t < 20000) begin
            rd(6'd4, d);
            t++;
        end
        check(t < 20000, "R6", "queue finishes", 32'(t), 32'd20000);
        check(d[2:0] == 3'b010, "R6", "status after queue", 32'(d[2:0]), 32'h2);
        check(sb.size() == 0, "R5", "all entries transferred", 32'(sb.size()), 32'd0);
        check(sck_o == tb_cpol && cs_o == idle_cs, "R7", "pins at idle levels",
              32'({sck_o, cs_o}), 32'({tb_cpol, idle_cs}));
        i = st;
        forever begin
            rd(6'(48 + i), d);
            check(d == exp_rx[i], "R5", $sformatf("rx entry %0d", i), 32'(d), 32'(exp_rx[i]));
            if (i == en) break;
            i = (i + 1) % 16;
        end
    endtask

    task automatic measure_period(output int clocks);
        realtime t0, t1;
        @(posedge sck_o);
        t0 = $realtime;
        @(posedge sck_o);
        t1 = $realtime;
        clocks = int'((t1 - t0) / CLK_PERIOD);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int per;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(6'd4, d);
        check(d[2:0] == 3'b000, "R6", "status after reset", 32'(d[2:0]), 32'h0);
        check(sck_o == 1'b0 && cs_o == 4'hF, "R7", "idle pins after reset",
              32'({sck_o, cs_o}), 32'h0F);
        check(sck_oe && mosi_oe && cs_oe == 4'hF, "R10", "enables with push-pull",
              32'({sck_oe, mosi_oe, cs_oe}), 32'h3F);

        // all four clock modes, mixed widths
        for (int m = 0; m < 4; m++) begin
            logic [3:0] ic;
            ic = 4'hF - 4'(m);
            set_mode(m[0], m[1], 1'b0, 5'd12, ic);
            wr(6'd1, 16'(2 + m));
            @(negedge clk);
            check(sck_o == m[0], "R1", $sformatf("resting clock mode %0d", m),
                  32'(sck_o), 32'(m[0]));
            load_entry(0, 4'hE, 1'b0, 16'h00A5, 16'h003C, 8);
            load_entry(1, 4'hD, 1'b1, 16'h0ABC, 16'h05A6, 12);
            load_entry(2, 4'h7, 1'b0, 16'hFF81, 16'h127E, 8);
            start_q(0, 2);
            wait_q(0, 2, ic);
        end

        // width 16 and clamped width request of 20
        set_mode(1'b0, 1'b0, 1'b0, 5'd16, 4'hF);
        wr(6'd1, 16'd2);
        load_entry(3, 4'hB, 1'b1, 16'hC3A1, 16'h8E17, 16);
        start_q(3, 3);
        wait_q(3, 3, 4'hF);
        set_mode(1'b1, 1'b1, 1'b0, 5'd20, 4'hF);
        load_entry(4, 4'h3, 1'b1, 16'h1234, 16'hFEDC, 16);
        load_entry(5, 4'h5, 1'b0, 16'h5A96, 16'h0F69, 8);
        start_q(4, 5);
        wait_q(4, 5, 4'hF);

        // width request below range clamps to 8 (R3)
        set_mode(1'b0, 1'b1, 1'b0, 5'd3, 4'hF);
        load_entry(6, 4'h9, 1'b1, 16'h00C7, 16'h0093, 8);
        start_q(6, 6);
        wait_q(6, 6, 4'hF);

        // queue wrap from slot 15 to slot 0
        set_mode(1'b0, 1'b0, 1'b0, 5'd10, 4'hF);
        load_entry(14, 4'hE, 1'b0, 16'h0011, 16'h0088, 8);
        load_entry(15, 4'hD, 1'b1, 16'h0322, 16'h0244, 10);
        load_entry(0,  4'hB, 1'b0, 16'h0033, 16'h00CC, 8);
        load_entry(1,  4'h7, 1'b1, 16'h0144, 16'h0399, 10);
        start_q(14, 1);
        wait_q(14, 1, 4'hF);

        // clock period R4: divider 0 and 5
        wr(6'd1, 16'd0);
        load_entry(7, 4'hE, 1'b0, 16'h00F0, 16'h000F, 8);
        fork
            begin start_q(7, 7); wait_q(7, 7, 4'hF); end
            measure_period(per);
        join
        check(per == 4, "R4", "period with divider 0", 32'(per), 32'd4);
        wr(6'd1, 16'd5);
        load_entry(7, 4'hE, 1'b0, 16'h0055, 16'h00AA, 8);
        fork
            begin start_q(7, 7); wait_q(7, 7, 4'hF); end
            measure_period(per);
        join
        check(per == 10, "R4", "period with divider 5", 32'(per), 32'd10);

        // second start while running is ignored (R9)
        wr(6'd1, 16'd3);
        load_entry(8, 4'hE, 1'b0, 16'h0081, 16'h0042, 8);
        load_entry(9, 4'hD, 1'b0, 16'h0018, 16'h0024, 8);
        start_q(8, 9);
        repeat (20) @(negedge clk);
        wr(6'd4, 16'h0001);
        wait_q(8, 9, 4'hF);
        extra_edges = 0;
        repeat (200) @(negedge clk);
        check(extra_edges == 0, "R9", "no clocks after ignored start", 32'(extra_edges), 32'd0);

        // mode fault mid-word (R8) and blocked start (R9)
        set_mode(1'b1, 1'b0, 1'b0, 5'd16, 4'hA);
        wr(6'd1, 16'd4);
        load_entry(10, 4'h6, 1'b1, 16'hBEEF, 16'h1357, 16);
        load_entry(11, 4'h9, 1'b1, 16'hCAFE, 16'h2468, 16);
        start_q(10, 11);
        repeat (12) @(negedge clk);
        ss_n = 1'b0;
        repeat (5) @(negedge clk);
        rd(6'd4, d);
        check(d[2:0] == 3'b100, "R8", "status after mode fault", 32'(d[2:0]), 32'h4);
        check(sck_o == 1'b1 && cs_o == 4'hA, "R8", "pins idle after fault",
              32'({sck_o, cs_o}), 32'h1A);
        sb.delete();
        k = 0;
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        extra_edges = 0;
        wr(6'd4, 16'h0001);
        repeat (30) @(negedge clk);
        rd(6'd4, d);
        check(d[2:0] == 3'b100, "R9", "start refused during fault", 32'(d[2:0]), 32'h4);
        check(extra_edges == 0, "R9", "no clock after refused start", 32'(extra_edges), 32'd0);
        wr(6'd4, 16'h0004);
        rd(6'd4, d);
        check(d[2:0] == 3'b000, "R9", "fault flag cleared", 32'(d[2:0]), 32'h0);
        load_entry(10, 4'h6, 1'b1, 16'hBEEF, 16'h1357, 16);
        start_q(10, 10);
        wait_q(10, 10, 4'hA);

        // open-drain enables (R10)
        set_mode(1'b0, 1'b0, 1'b1, 5'd8, 4'h5);
        @(negedge clk);
        check(sck_oe == ~sck_o && cs_oe == ~cs_o && mosi_oe == ~mosi_o, "R10",
              "open-drain idle enables", 32'({sck_oe, cs_oe, mosi_oe}),
              32'({~sck_o, ~cs_o, ~mosi_o}));
        load_entry(12, 4'hC, 1'b0, 16'h00B4, 16'h004B, 8);
        start_q(12, 12);
        repeat (9) @(negedge clk);
        check(sck_oe == ~sck_o && cs_oe == ~cs_o && mosi_oe == ~mosi_o, "R10",
              "open-drain enables mid-word", 32'({sck_oe, cs_oe, mosi_oe}),
              32'({~sck_o, ~cs_o, ~mosi_o}));
        wait_q(12, 12, 4'h5);
        set_mode(1'b0, 1'b0, 1'b0, 5'd8, 4'hF);
        @(negedge clk);
        check(sck_oe && mosi_oe && cs_oe == 4'hF, "R10", "push-pull enables restored",
              32'({sck_oe, mosi_oe, cs_oe}), 32'h3F);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule